// File: doc/BRIEF.md
# Sixteen-Channel PWM Generator with Per-Channel Shadowed Duty Updates

This block drives sixteen pulse-width-modulated outputs from one shared timebase. A prescaler divides the clock into counter steps. A period counter runs from zero up to a programmed terminal value and then wraps. Each channel has two position registers. Its output goes high when the counter reaches the rise position and goes low when the counter reaches the fall position. If the two positions are equal, the channel stays low. The terminal value and the prescale divisor are latched into the timebase only at a period boundary, so a running period is never cut short or stretched.

Each channel can be built, through a bit in a build-time mask, with a second buffered copy of its two position registers. A run-time mask with one bit per channel then chooses the update style for those channels:
- In synchronous style, register writes land in the buffer. The buffers of all such channels are copied into the comparators together on the cycle the counter wraps.
- In immediate style, and always on channels built without the buffer, a write reaches the comparator on the next clock. This may glitch the current period.

Configuration uses a zero-wait APB-style write port. The four control words can be read back.

Top module: `pwmx_top`

## Requirements
- R1: After reset every PWM output is low, and the prescale, period, enable and sync-mode words all read as zero.
- R2: Byte addresses: 0x00 prescale, 0x04 period, 0x08 enable mask, 0x0C sync mask. Channel n has its rise position at 0x10+8n and its fall position at 0x14+8n. A write happens when psel, penable and pwrite are all high on a clock edge. The four control words read back on prdata while psel is high; any other address reads zero.
- R3: The counter holds each value for prescale+1 clocks and counts 0..period, so one PWM period lasts (prescale+1)*(period+1) clocks.
- R4: An enabled channel goes high when the counter equals rise and low when it equals fall. With rise<fall it is high for (fall-rise)*(prescale+1) clocks per period. With rise>fall the high time wraps through zero: (period+1-rise+fall)*(prescale+1). If fall is never reached, the output stays high.
- R5: A channel whose rise and fall positions are equal is low on the following clock and for the whole period.
- R6: A channel whose enable bit (bit n of 0x08) is clear is low on the following clock.
- R7: Sync-mask bits for channels built without a buffer are dropped on write: they read back as 0 and do not change how the channel updates.
- R8: On a buffered channel with its sync bit set, writes to its rise/fall positions do not affect the output in the current period. Both positions take effect together from the next period.
- R9: On an unbuffered channel, or a buffered one with its sync bit clear, a position write affects the output within the current period.
- R10: New period and prescale values take effect only at the next counter wrap; the period in progress keeps its old length.
- R11: The counter never exceeds the active period value and restarts at zero after each wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | High for a write |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the control words |
| pwm_out | output | 16 | PWM outputs, one per channel |

## Verification
Four properties are checked on every clock:
- the counter stays within the active period and restarts at zero after a wrap;
- the active period is held between wraps;
- disabled channels and channels with equal positions are low;
- on buffered channels in sync style, the active positions never move except at a wrap.

Only the bench scenarios can show the duty lengths under different prescale and period settings, the wrap-around and never-cleared shapes, and the contrast between held and immediate writes landing in the middle of one period. They also cover the period lengths measured across a mid-period change of period and of prescale.

// File: rtl/pwmx_pkg.sv
`timescale 1ns/1ps
// Shared constants for the multichannel PWM: register byte offsets.
// Assumes 32-bit data words on a byte-addressed register port.
package pwmx_pkg;
    localparam int ADR_PRESCALE  = 'h00;
    localparam int ADR_PERIOD    = 'h04;
    localparam int ADR_ENABLE    = 'h08;
    localparam int ADR_SYNC      = 'h0C;
    localparam int ADR_DUTY_BASE = 'h10;
    localparam int DUTY_STRIDE   = 8;
    localparam int FALL_OFFSET   = 4;
endpackage

// File: rtl/pwmx_timebase.sv
`timescale 1ns/1ps
// Prescaler and period counter shared by all channels.
// Period and prescale settings are latched only on the wrap cycle,
// which is also reported as period_start. Assumes rst_n is synchronous.
module pwmx_timebase #(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_prescale,
    input  logic [CW-1:0] cfg_period,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] period_act,
    output logic          period_start
);
    logic [PW-1:0] pre_act;
    logic [PW-1:0] pre_cnt;
    logic          tick;

    // a counter step happens once the prescaler reaches its active limit
    assign tick         = (pre_cnt == pre_act);
    assign period_start = tick && (cnt == period_act);

    // prescaler, period counter and boundary latching of the settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt    <= '0;
            pre_act    <= '0;
            period_act <= '0;
            cnt        <= '0;
        end else begin
            if (tick) pre_cnt <= '0;
            else      pre_cnt <= pre_cnt + 1'b1;
            if (period_start) begin
                cnt        <= '0;
                period_act <= cfg_period;
                pre_act    <= cfg_prescale;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmx_regs.sv
`timescale 1ns/1ps
// Register file: control words, per-channel position registers and the
// optional buffer copies chosen by SHADOW_MASK. Buffered channels in sync
// style commit both positions on period_start; all others update at once.
// Assumes a zero-wait write when psel, penable and pwrite are high.
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int            NCH         = 16,
    parameter int            CW          = 16,
    parameter int            PW          = 16,
    parameter int            AW          = 8,
    parameter logic [NCH-1:0] SHADOW_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [AW-1:0]           paddr,
    input  logic [31:0]             pwdata,
    input  logic                    period_start,
    output logic [31:0]             prdata,
    output logic [PW-1:0]           cfg_prescale,
    output logic [CW-1:0]           cfg_period,
    output logic [NCH-1:0]          ch_en,
    output logic [NCH-1:0]          sync_q,
    output logic [NCH-1:0][CW-1:0]  act_rise,
    output logic [NCH-1:0][CW-1:0]  act_fall
);
    localparam logic [AW-1:0] A_PRE  = AW'(ADR_PRESCALE);
    localparam logic [AW-1:0] A_PER  = AW'(ADR_PERIOD);
    localparam logic [AW-1:0] A_EN   = AW'(ADR_ENABLE);
    localparam logic [AW-1:0] A_SYNC = AW'(ADR_SYNC);

    logic wr;
    assign wr = psel && penable && pwrite;

    // control words; sync bits of unbuffered channels are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_prescale <= '0;
            cfg_period   <= '0;
            ch_en        <= '0;
            sync_q       <= '0;
        end else if (wr) begin
            if (paddr == A_PRE)  cfg_prescale <= pwdata[PW-1:0];
            if (paddr == A_PER)  cfg_period   <= pwdata[CW-1:0];
            if (paddr == A_EN)   ch_en        <= pwdata[NCH-1:0];
            if (paddr == A_SYNC) sync_q       <= pwdata[NCH-1:0] & SHADOW_MASK;
        end
    end

    // readback of the control words only
    always_comb begin
        prdata = '0;
        if (psel) begin
            case (paddr)
                A_PRE:   prdata = 32'(cfg_prescale);
                A_PER:   prdata = 32'(cfg_period);
                A_EN:    prdata = 32'(ch_en);
                A_SYNC:  prdata = 32'(sync_q);
                default: prdata = '0;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] A_RISE = AW'(ADR_DUTY_BASE + DUTY_STRIDE * i);
        localparam logic [AW-1:0] A_FALL = AW'(ADR_DUTY_BASE + DUTY_STRIDE * i + FALL_OFFSET);
        logic          wr_rise, wr_fall;
        logic [CW-1:0] rise_q, fall_q;

        assign wr_rise     = wr && (paddr == A_RISE);
        assign wr_fall     = wr && (paddr == A_FALL);
        assign act_rise[i] = rise_q;
        assign act_fall[i] = fall_q;

        if (SHADOW_MASK[i]) begin : g_buf
            logic [CW-1:0] buf_rise, buf_fall;

            // buffer copies always track writes
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    buf_rise <= '0;
                    buf_fall <= '0;
                end else begin
                    if (wr_rise) buf_rise <= pwdata[CW-1:0];
                    if (wr_fall) buf_fall <= pwdata[CW-1:0];
                end
            end

            // active positions: commit at the wrap in sync style, else direct
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_q <= '0;
                    fall_q <= '0;
                end else if (sync_q[i]) begin
                    if (period_start) begin
                        rise_q <= buf_rise;
                        fall_q <= buf_fall;
                    end
                end else begin
                    if (wr_rise) rise_q <= pwdata[CW-1:0];
                    if (wr_fall) fall_q <= pwdata[CW-1:0];
                end
            end
        end else begin : g_direct
            // unbuffered channel: writes go straight to the comparator
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_q <= '0;
                    fall_q <= '0;
                end else begin
                    if (wr_rise) rise_q <= pwdata[CW-1:0];
                    if (wr_fall) fall_q <= pwdata[CW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/pwmx_chan.sv
`timescale 1ns/1ps
// One PWM output: set on a rise match, cleared on a fall match, held low
// when disabled or when both positions are equal. Output is registered.
module pwmx_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] rise,
    input  logic [CW-1:0] fall,
    output logic          out
);
    // edge comparison; a fall match wins over a rise match
    always_ff @(posedge clk) begin
        if (!rst_n)                  out <= 1'b0;
        else if (!en || rise == fall) out <= 1'b0;
        else if (cnt == fall)         out <= 1'b0;
        else if (cnt == rise)         out <= 1'b1;
    end
endmodule

// File: rtl/pwmx_top.sv
`timescale 1ns/1ps
// Sixteen-channel PWM with a shared timebase and per-channel optional
// buffered duty registers. Assumes a zero-wait register port and a
// synchronous active-low reset.
module pwmx_top #(
    parameter int             NCH         = 16,
    parameter int             CW          = 16,
    parameter int             PW          = 16,
    parameter int             AW          = 8,
    parameter logic [NCH-1:0] SHADOW_MASK = 16'h00FF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [AW-1:0]  paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    output logic [NCH-1:0] pwm_out
);
    logic [PW-1:0]          cfg_prescale;
    logic [CW-1:0]          cfg_period;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         sync_q;
    logic [NCH-1:0][CW-1:0] act_rise;
    logic [NCH-1:0][CW-1:0] act_fall;
    logic [CW-1:0]          cnt;
    logic [CW-1:0]          period_act;
    logic                   period_start;

    pwmx_regs #(
        .NCH(NCH), .CW(CW), .PW(PW), .AW(AW), .SHADOW_MASK(SHADOW_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .period_start(period_start),
        .prdata(prdata),
        .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
        .ch_en(ch_en), .sync_q(sync_q),
        .act_rise(act_rise), .act_fall(act_fall)
    );

    pwmx_timebase #(.CW(CW), .PW(PW)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
        .cnt(cnt), .period_act(period_act), .period_start(period_start)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        pwmx_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .en(ch_en[i]), .cnt(cnt),
            .rise(act_rise[i]), .fall(act_fall[i]),
            .out(pwm_out[i])
        );
    end
endmodule

// File: rtl/pwmx_chk.sv
`timescale 1ns/1ps
// Checker for pwmx_top: timebase bounds, boundary-only period changes,
// low outputs for disabled or equal-position channels, and held
// positions on buffered channels in sync style.
module pwmx_chk #(
    parameter int             NCH         = 16,
    parameter int             CW          = 16,
    parameter logic [NCH-1:0] SHADOW_MASK = '1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CW-1:0]          cnt,
    input logic [CW-1:0]          period_act,
    input logic                   period_start,
    input logic [NCH-1:0]         ch_en,
    input logic [NCH-1:0]         sync_q,
    input logic [NCH-1:0][CW-1:0] act_rise,
    input logic [NCH-1:0][CW-1:0] act_fall,
    input logic [NCH-1:0]         pwm_out
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= period_act); // R11
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (cnt == '0)); // R11
    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(period_act)); // R10

    for (genvar i = 0; i < NCH; i++) begin : g_ck
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |=> !pwm_out[i]); // R6
        AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act_rise[i] == act_fall[i]) |=> !pwm_out[i]); // R5
        if (SHADOW_MASK[i]) begin : g_sh
            AST_SYNC_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_q[i] && !period_start) |=> $stable(act_rise[i])); // R8
            AST_SYNC_FALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_q[i] && !period_start) |=> $stable(act_fall[i])); // R8
        end
    end
endmodule

bind pwmx_top pwmx_chk #(
    .NCH(NCH), .CW(CW), .SHADOW_MASK(SHADOW_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .period_act(period_act),
    .period_start(period_start), .ch_en(ch_en), .sync_q(sync_q),
    .act_rise(act_rise), .act_fall(act_fall), .pwm_out(pwm_out)
);

// File: tb/sim_pwmx_top.sv
`timescale 1ns/1ps
module sim_pwmx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [15:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwmx_top u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pwm_out(pwm_out)
    );

    // prescale, period, rise, fall, expected high clocks per period (channel 12)
    localparam int VEC [0:6][0:4] = '{
        '{0, 99, 10, 30, 20},
        '{1, 49,  5, 25, 40},
        '{3, 19,  0, 10, 40},
        '{0, 63, 40, 10, 34},
        '{2, 31,  7,  7,  0},
        '{0, 15,  4, 20, 16},
        '{4,  9,  1,  9, 40}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = 8'(a); pwdata = 32'(d); penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = 8'(a); penable = 0;
        @(negedge clk);
        penable = 1;
        #1 d = int'(prdata);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, hi;
        realtime t0, t1;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 outputs low in reset", int'(pwm_out), 0);
        @(negedge clk); rst_n = 1;
        wait_clk(3);
        check("R1 outputs low after reset", int'(pwm_out), 0);
        rd('h00, v); check("R1 prescale reset", v, 0);
        rd('h04, v); check("R1 period reset", v, 0);
        rd('h08, v); check("R1 enable reset", v, 0);
        rd('h0C, v); check("R1 sync reset", v, 0);

        // R2, R7: control readback; unbuffered sync bits dropped
        wr('h08, 'h7FFF);
        rd('h08, v); check("R2 enable readback", v, 'h7FFF);
        wr('h0C, 'hFFFF);
        rd('h0C, v); check("R7 sync bits of unbuffered channels read 0", v, 'h00FF);

        // R3 R4 R5: vector table on unbuffered channel 12
        for (int i = 0; i < 7; i++) begin
            wr('h00, VEC[i][0]);
            wr('h04, VEC[i][1]);
            wr('h10 + 8*12, VEC[i][2]);
            wr('h14 + 8*12, VEC[i][3]);
            wait_clk(400);
            count_high(12, (VEC[i][0] + 1) * (VEC[i][1] + 1), hi);
            check($sformatf("R3/R4/R5 vector %0d high clocks", i), hi, VEC[i][4]);
        end
        rd('h00, v); check("R2 prescale readback", v, 4);

        // R6: disabled channel 15 stays low
        wr('h10 + 8*15, 0);
        wr('h14 + 8*15, 5);
        wait_clk(100);
        count_high(15, 50, hi);
        check("R6 disabled channel low", hi, 0);

        // setup for update-style tests
        wr('h00, 0);
        wr('h04, 99);
        wr('h0C, 'hFFFB);
        rd('h0C, v); check("R7 sync readback after mask", v, 'h00FB);
        wr('h10 + 8*9, 0);   wr('h14 + 8*9, 50);
        wr('h10 + 8*1, 10);  wr('h14 + 8*1, 20);
        wr('h10 + 8*2, 10);  wr('h14 + 8*2, 20);
        wr('h10 + 8*10, 10); wr('h14 + 8*10, 20);
        wait_clk(300);

        // R8 R9: mid-period writes to fall=90 then rise=70
        @(posedge pwm_out[9]);
        wr('h14 + 8*1, 90);  wr('h10 + 8*1, 70);
        wr('h14 + 8*2, 90);  wr('h10 + 8*2, 70);
        wr('h14 + 8*10, 90); wr('h10 + 8*10, 70);
        @(negedge pwm_out[9]);
        wait_clk(29);   // counter at 80
        check("R9 buffered channel in immediate style", int'(pwm_out[2]), 1);
        check("R9 unbuffered channel with sync bit written", int'(pwm_out[10]), 1);
        check("R8 sync channel holds old positions", int'(pwm_out[1]), 0);
        @(posedge pwm_out[9]);
        wait_clk(13);   // counter at 14
        check("R8 old rise/fall gone next period", int'(pwm_out[1]), 0);
        wait_clk(66);   // counter at 80
        check("R8 new positions active next period", int'(pwm_out[1]), 1);

        // R10: period and prescale changes wait for the wrap
        wr('h14 + 8*9, 20);
        @(posedge pwm_out[9]);
        t0 = $realtime;
        wr('h04, 49);
        @(posedge pwm_out[9]); t1 = $realtime;
        check("R10 period change holds current period", int'((t1 - t0) / 5.0), 100);
        t0 = t1;
        wr('h00, 1);
        @(posedge pwm_out[9]); t1 = $realtime;
        check("R10 new period after wrap", int'((t1 - t0) / 5.0), 50);
        t0 = t1;
        @(posedge pwm_out[9]); t1 = $realtime;
        check("R3 R10 prescale applied after wrap", int'((t1 - t0) / 5.0), 100);

        // R11: reset mid-run brings outputs low again
        @(negedge clk); rst_n = 0;
        wait_clk(2);
        check("R1 R11 outputs low on reset", int'(pwm_out), 0);
        @(negedge clk); rst_n = 1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule